// File: doc/BRIEF.md
# Shadow Scan Register with Transfer and Capture

This block pairs a functional register with a separate shadow scan register of the same width. The functional register is the only register on the normal data path. It loads its parallel input on every clock, and its output drives the downstream logic under test. The shadow register sits beside it and is reached only through a serial scan input and a serial scan output. Shifting therefore never disturbs the functional path, and the circuit keeps working while a test vector moves through the shadow chain.

A test runs in four steps. The test vector is shifted serially into the shadow register. A transfer then copies the whole shadow register into the functional register for one clock, so the vector reaches the downstream logic. That logic's response comes back through the functional register's parallel input. A capture copies the functional register into the shadow register in parallel. The captured response is then shifted out serially. The three controls have a fixed priority, so any combination of control inputs gives a defined result.

Top module: `scan_shadow_top`

## Requirements
- R1: A synchronous active-high reset clears both the functional register and the shadow register to zero. After reset, `func_q` is 0 and `scan_out` is 0.
- R2: On any clock without an effective transfer, the functional register loads `func_d`. This holds even while the shadow register is shifting or capturing.
- R3: When shift is the effective operation, shadow bit 0 takes `scan_in` and each bit i > 0 takes the previous value of bit i-1. `scan_out` always shows shadow bit WIDTH-1, so a bit shifted in appears at `scan_out` after WIDTH shifts.
- R4: When transfer is the effective operation, the functional register loads the whole shadow register in parallel for exactly that one clock, in place of `func_d`. The shadow register keeps its value.
- R5: When capture is the effective operation, the shadow register loads the value the functional register held before the edge. The functional register still loads `func_d` on the same edge.
- R6: The controls are resolved by priority: `xfer_en` first, then `capture_en`, then `shift_en`. The lower-priority controls asserted in the same cycle have no effect.
- R7: When none of the three controls is asserted, the shadow register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| func_d | input | WIDTH | Parallel data input of the functional register |
| func_q | output | WIDTH | Functional register output, driving the logic under test |
| scan_in | input | 1 | Serial input into shadow bit 0 |
| scan_out | output | 1 | Serial output from shadow bit WIDTH-1 |
| shift_en | input | 1 | Shift the shadow register by one bit |
| xfer_en | input | 1 | Copy the shadow register into the functional register |
| capture_en | input | 1 | Copy the functional register into the shadow register |

## Verification
On every cycle after reset, the assertions check that the functional register follows `func_d` or, after a transfer, the shadow contents. On shift, capture and idle cycles they check the shadow register's next value against its previous value, `scan_in` and the functional register. The requirements on the reset value, on serial order as seen at the single output pin, and on combined controls are shown by the bench's scenarios. In those scenarios a known vector is shifted in, transferred, captured back and shifted out bit by bit. Conflicting controls are also driven together, and the shadow contents are then read out through `scan_out`.

// File: rtl/sscan_pkg.sv
package sscan_pkg;

    // Effective operation on the shadow register after priority resolution
    typedef enum logic [1:0] {
        SOP_HOLD    = 2'd0,
        SOP_SHIFT   = 2'd1,
        SOP_CAPTURE = 2'd2,
        SOP_XFER    = 2'd3
    } sop_e;

    // Per-cell control of a shadow cell
    typedef struct packed {
        logic en;       // cell updates this cycle
        logic sel_par;  // 1: take parallel value, 0: take serial predecessor
    } cell_ctl_t;

    // Functional register control
    typedef struct packed {
        logic from_shadow;  // 1: load shadow contents, 0: load func_d
    } freg_ctl_t;

    // Transfer over capture over shift
    function automatic sop_e sop_pick(input logic shift, input logic capture,
                                      input logic xfer);
        sop_e op;
        if (xfer)         op = SOP_XFER;
        else if (capture) op = SOP_CAPTURE;
        else if (shift)   op = SOP_SHIFT;
        else              op = SOP_HOLD;
        return op;
    endfunction

    function automatic cell_ctl_t cell_ctl_of(input sop_e op);
        cell_ctl_t c;
        c.en      = (op == SOP_SHIFT) || (op == SOP_CAPTURE);
        c.sel_par = (op == SOP_CAPTURE);
        return c;
    endfunction

endpackage

// File: rtl/sscan_decode.sv
module sscan_decode
    import sscan_pkg::*;
(
    input  logic      shift_en,
    input  logic      capture_en,
    input  logic      xfer_en,
    output cell_ctl_t cell_ctl,
    output freg_ctl_t freg_ctl
);
    sop_e op;

    always_comb begin
        op                   = sop_pick(shift_en, capture_en, xfer_en);
        cell_ctl             = cell_ctl_of(op);
        freg_ctl.from_shadow = (op == SOP_XFER);
    end
endmodule

// File: rtl/sscan_cell.sv
module sscan_cell
    import sscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_ctl_t ctl,
    input  logic      ser_d,
    input  logic      par_d,
    output logic      q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ctl.en)
            q <= ctl.sel_par ? par_d : ser_d;
    end
endmodule

// File: rtl/sscan_shadow.sv
module sscan_shadow
    import sscan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_ctl_t        ctl,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = ser_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        sscan_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .ser_d (chain[i]),
            .par_d (par_d[i]),
            .q     (q[i])
        );
        assign chain[i+1] = q[i];
    end

    logic unused_tail;
    assign unused_tail = chain[LAST+1];
endmodule

// File: rtl/sscan_func_reg.sv
module sscan_func_reg
    import sscan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  freg_ctl_t        ctl,
    input  logic [WIDTH-1:0] func_d,
    input  logic [WIDTH-1:0] shadow_d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ctl.from_shadow)
            q <= shadow_d;
        else
            q <= func_d;
    end
endmodule

// File: rtl/scan_shadow_top.sv
module scan_shadow_top
    import sscan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] func_d,
    output logic [WIDTH-1:0] func_q,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic             shift_en,
    input  logic             xfer_en,
    input  logic             capture_en
);
    localparam int MSB = WIDTH - 1;

    cell_ctl_t        cell_ctl;
    freg_ctl_t        freg_ctl;
    logic [WIDTH-1:0] shadow_q;

    sscan_decode u_dec (
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .xfer_en    (xfer_en),
        .cell_ctl   (cell_ctl),
        .freg_ctl   (freg_ctl)
    );

    sscan_func_reg #(.WIDTH(WIDTH)) u_freg (
        .clk      (clk),
        .rst      (rst),
        .ctl      (freg_ctl),
        .func_d   (func_d),
        .shadow_d (shadow_q),
        .q        (func_q)
    );

    sscan_shadow #(.WIDTH(WIDTH)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .ctl    (cell_ctl),
        .ser_in (scan_in),
        .par_d  (func_q),
        .q      (shadow_q)
    );

    assign scan_out = shadow_q[MSB];
endmodule

// File: rtl/sscan_checker.sv
module sscan_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_en,
    input logic             xfer_en,
    input logic             capture_en,
    input logic             scan_in,
    input logic [WIDTH-1:0] func_d,
    input logic [WIDTH-1:0] func_q,
    input logic [WIDTH-1:0] shadow
);
    // prev_live: the previous cycle was out of reset, after a reset was seen
    logic seen_rst  = 1'b0;
    logic prev_live = 1'b0;

    always_ff @(posedge clk) begin
        seen_rst  <= seen_rst | rst;
        prev_live <= seen_rst & ~rst;
    end

    // R2: functional load whenever no transfer
    p_func_load_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_live && !$past(xfer_en)) |-> (func_q == $past(func_d)));

    // R4, R6: transfer wins, shadow holds
    p_xfer_r4: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(xfer_en)) |-> (func_q == $past(shadow) && shadow == $past(shadow)));

    // R5, R6: capture wins over shift
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(capture_en && !xfer_en)) |-> (shadow == $past(func_q)));

    // R3: serial shift order
    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(shift_en && !xfer_en && !capture_en))
        |-> (shadow == {$past(shadow[WIDTH-2:0]), $past(scan_in)}));

    // R7: idle holds the shadow
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(!shift_en && !xfer_en && !capture_en)) |-> $stable(shadow));
endmodule

bind scan_shadow_top sscan_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .xfer_en    (xfer_en),
    .capture_en (capture_en),
    .scan_in    (scan_in),
    .func_d     (func_d),
    .func_q     (func_q),
    .shadow     (shadow_q)
);

// File: tb/tb_scan_shadow_top.sv
`timescale 1ns/1ps
module tb_scan_shadow_top;
    localparam int W = 8;
    localparam real HALF = 4.0;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] func_d;
    logic [W-1:0] func_q;
    logic         scan_in, scan_out, shift_en, xfer_en, capture_en;

    int n_checks = 0;
    int n_fail   = 0;

    // bench-side expectation, built from the requirements
    logic [W-1:0] m_r, m_rs;

    always #(HALF) clk = ~clk;

    scan_shadow_top #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .func_d(func_d), .func_q(func_q),
        .scan_in(scan_in), .scan_out(scan_out),
        .shift_en(shift_en), .xfer_en(xfer_en), .capture_en(capture_en)
    );

    // {shift, xfer, capture, scan_in, func_d}
    localparam logic [11:0] STIM [16] = '{
        12'h8A5, 12'h93C, 12'h9FF, 12'h800,
        12'h911, 12'h2C3, 12'h000, 12'h4AA,
        12'h055, 12'h6F0, 12'hA12, 12'hC34,
        12'hE99, 12'h977, 12'h2E1, 12'h4F2
    };

    task automatic check_val(input string req, input logic [W-1:0] act,
                             input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic sh, input logic xf, input logic cp,
                        input logic si, input logic [W-1:0] d);
        logic [W-1:0] old_r;
        string tag_s;
        string tag_f;
        @(negedge clk);
        shift_en = sh; xfer_en = xf; capture_en = cp; scan_in = si; func_d = d;
        @(posedge clk);
        #1;
        old_r = m_r;
        if (xf) m_r = m_rs; else m_r = d;                    // R2, R4
        if (!xf && cp)      m_rs = old_r;                     // R5
        else if (!xf && sh) m_rs = {m_rs[W-2:0], si};         // R3
        tag_f = xf ? "R4" : "R2";
        if (xf && (sh || cp))      tag_s = "R6";
        else if (xf)               tag_s = "R4";
        else if (cp && sh)         tag_s = "R6";
        else if (cp)               tag_s = "R5";
        else if (sh)               tag_s = "R3";
        else                       tag_s = "R7";
        check_val(tag_f, func_q, m_r);
        check_val(tag_s, {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, m_rs[W-1]});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(2.0 * HALF * 100000.0);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; func_d = 8'h5A; scan_in = 1'b1;
        shift_en = 1'b1; xfer_en = 1'b0; capture_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset clears both registers
        check_val("R1", func_q, '0);
        check_val("R1", {{(W-1){1'b0}}, scan_out}, '0);
        m_r = '0; m_rs = '0;
        @(negedge clk);
        rst = 1'b0;

        // R1: shadow is all zero, ones shifted in show up only after W shifts
        for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        check_val("R1", {{(W-1){1'b0}}, scan_out}, 8'h01);

        // vector table
        for (int i = 0; i < 16; i++)
            step(STIM[i][11], STIM[i][10], STIM[i][9], STIM[i][8], STIM[i][7:0]);

        // known vector B4, MSB first, then transfer (R3, R4)
        for (int i = W-1; i >= 0; i--) step(1'b1, 1'b0, 1'b0, 1'(8'hB4 >> i), 8'h11);
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h22);
        check_val("R4", func_q, 8'hB4);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
        check_val("R2", func_q, 8'h3C);

        // capture 3C then shift out MSB first (R5, R3)
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h77);
        for (int i = W-1; i >= 0; i--) begin
            check_val("R5", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, 1'(8'h3C >> i)});
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        end

        // priority: all controls at once keep the shadow (R6)
        for (int i = W-1; i >= 0; i--) step(1'b1, 1'b0, 1'b0, 1'(8'hC9 >> i), 8'h00);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h0F);
        check_val("R6", func_q, 8'hC9);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 8'h66);   // R7 idle
        for (int i = W-1; i >= 0; i--) begin
            check_val("R6", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, 1'(8'hC9 >> i)});
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        end

        finish_run();
    end
endmodule